// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath. It walks through one state per clock and drives every datapath enable and multiplexer select as a pure function of the current state. The zero flag is the single exception: it gates the conditional PC update. It handles register-to-register arithmetic and logic, word loads and stores, branch on equal, absolute jump, and a halt instruction. The datapath, memory and register file sit outside the block. They feed it the 6-bit opcode of the latched instruction and the ALU zero flag.

Each instruction first passes through a common fetch step and a common decode step. Decode reads both source registers and precomputes a branch target. The opcode then picks a short execution path, and every path returns to fetch. The sequencer leaves reset in an idle halted state. A `start` pulse in any state enters a boot cycle that loads the boot address into the PC, and fetching begins on the next cycle. The parameter `FETCH_WAIT` adds wait cycles for a slow instruction memory. With wait cycles present, the instruction register is written only in the last fetch cycle, and a separate cycle then advances the PC by 4 before decode.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high, and after its release until `start` is seen, every output is 0 (the idle halted state), whatever the opcode.
- R2: A `start` high at a clock edge, in any state, gives one boot cycle in which only `pc_write`, `pc_en` and `pc_src`=3 (boot address) are asserted. The fetch begins on the next cycle.
- R3: With `FETCH_WAIT`=0 the fetch cycle asserts `mem_read`, `ir_write`, `pc_write` and `pc_en`, with `alu_src_b`=1 (constant 4). `mem_addr_sel`=0 (PC), `alu_src_a`=0 (PC), `alu_class`=0 (add) and `pc_src`=0 (ALU result). Decode follows.
- R4: The decode cycle asserts `a_load`, `b_load` and `aluout_load` with `alu_src_a`=0 and `alu_src_b`=3 (immediate shifted left 2). These outputs are the same for every opcode.
- R5: After decode the opcode selects the next step: 35 (load) and 43 (store) go to address computation, 0 to register execute, 4 to branch and 2 to jump. 63 (halt) and any other value go to the halted state, which then holds regardless of opcode until `start`.
- R6: Load path: the address cycle (`aluout_load`, `alu_src_a`=1, `alu_src_b`=2 sign-extended immediate) is followed by a memory read cycle (`mem_read`, `mem_addr_sel`=1, `mdr_load`). A write-back cycle (`reg_write`, `mem_to_reg`=1, `reg_dst`=0 rt) comes next, then fetch.
- R7: Store path: the address cycle is followed by a memory write cycle (`mem_write`, `mem_addr_sel`=1), then fetch.
- R8: Register path: the execute cycle (`aluout_load`, `alu_src_a`=1, `alu_src_b`=0 B, `alu_class`=2 function field) is followed by a write-back cycle (`reg_write`, `reg_dst`=1 rd, `mem_to_reg`=0), then fetch.
- R9: Branch cycle: `pc_write_cond`=1, `alu_src_a`=1, `alu_src_b`=0, `alu_class`=1 (subtract), `pc_src`=1 (ALUOut). `pc_en` equals `zero` within that cycle. Fetch follows.
- R10: Jump cycle: `pc_write`, `pc_en` and `pc_src`=2 (jump target), then fetch.
- R11: With `FETCH_WAIT`=N>0 the fetch lasts N+1 cycles with `mem_read` high and `pc_write` low, and `ir_write` is high only in the last of them. One cycle follows with `pc_write`, `pc_en`, `alu_src_a`=0, `alu_src_b`=1, `alu_class`=0 and `pc_src`=0, then decode.
- R12: Every output not named for a state is 0 in that state, and `mem_read` and `mem_write` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Enter boot cycle, then fetch |
| opcode | input | 6 | Opcode field of the latched instruction |
| zero | input | 1 | ALU zero flag |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC write request |
| pc_write_cond | output | 1 | PC write request gated by zero |
| pc_en | output | 1 | Resulting PC load enable |
| a_load | output | 1 | Load register A |
| b_load | output | 1 | Load register B |
| aluout_load | output | 1 | Load ALUOut register |
| mdr_load | output | 1 | Load memory data register |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 1 | Destination: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data: 0 ALUOut, 1 MDR |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B: 0 B, 1 four, 2 immediate, 3 immediate shifted 2 |
| alu_class | output | 2 | 0 add, 1 subtract, 2 function field |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALUOut, 2 jump target, 3 boot address |

## Verification
The bench builds two copies of the block. The first has `FETCH_WAIT`=0, which folds fetch and PC increment into one cycle. Every instruction path runs on this copy, along with both branch outcomes, a restart in the middle of an instruction, and both the halt opcode and an unlisted one. The second has `FETCH_WAIT`=2. This brings the wait-cycle counter, the late instruction register write and the separate PC increment cycle into reach, so the cycle-exact fetch length can be checked.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_MEMRD  = 4'd3,
      ST_WBMEM  = 4'd4,
      ST_MEMWR  = 4'd5,
      ST_EXEC   = 4'd6,
      ST_WBALU  = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9,
      ST_HALT   = 4'd10,
      ST_BOOT   = 4'd11,
      ST_PCINC  = 4'd12
   } state_e;

   localparam logic [1:0] ALU_ADD   = 2'd0;
   localparam logic [1:0] ALU_SUB   = 2'd1;
   localparam logic [1:0] ALU_FUNCT = 2'd2;

   localparam logic [1:0] SRCB_REG   = 2'd0;
   localparam logic [1:0] SRCB_FOUR  = 2'd1;
   localparam logic [1:0] SRCB_IMM   = 2'd2;
   localparam logic [1:0] SRCB_IMMSH = 2'd3;

   localparam logic [1:0] PCS_ALU    = 2'd0;
   localparam logic [1:0] PCS_ALUOUT = 2'd1;
   localparam logic [1:0] PCS_JUMP   = 2'd2;
   localparam logic [1:0] PCS_BOOT   = 2'd3;

   typedef struct packed {
      logic       ir_write;
      logic       pc_write;
      logic       pc_write_cond;
      logic       a_load;
      logic       b_load;
      logic       aluout_load;
      logic       mdr_load;
      logic       mem_read;
      logic       mem_write;
      logic       mem_addr_sel;
      logic       reg_write;
      logic       reg_dst;
      logic       mem_to_reg;
      logic       alu_src_a;
      logic [1:0] alu_src_b;
      logic [1:0] alu_class;
      logic [1:0] pc_src;
   } ctrl_t;

endpackage

// File: rtl/mc_fetch_timer.sv
module mc_fetch_timer #(
   parameter int FETCH_WAIT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic in_fetch,
   output logic fetch_last
);
   localparam int CW = (FETCH_WAIT < 1) ? 1 : $clog2(FETCH_WAIT + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(FETCH_WAIT);

   logic [CW-1:0] cnt_q;

   assign fetch_last = (cnt_q == LAST_CNT);

   always_ff @(posedge clk) begin
      if (rst || !in_fetch) begin
         cnt_q <= '0;
      end else if (!fetch_last) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
   import mc_ctrl_pkg::*;
#(
   parameter int          FETCH_WAIT = 0,
   parameter int          OPCODE_W   = 6,
   parameter logic [5:0]  OP_RTYPE   = 6'd0,
   parameter logic [5:0]  OP_LW      = 6'd35,
   parameter logic [5:0]  OP_SW      = 6'd43,
   parameter logic [5:0]  OP_BEQ     = 6'd4,
   parameter logic [5:0]  OP_J       = 6'd2,
   parameter logic [5:0]  OP_HALT    = 6'd63
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic [OPCODE_W-1:0] opcode,
   input  logic                fetch_last,
   output state_e              state
);
   localparam state_e AFTER_FETCH = (FETCH_WAIT == 0) ? ST_DECODE : ST_PCINC;

   state_e nxt;

   always_comb begin
      nxt = ST_HALT;
      unique case (state)
         ST_FETCH:  nxt = fetch_last ? AFTER_FETCH : ST_FETCH;
         ST_PCINC:  nxt = ST_DECODE;
         ST_DECODE: begin
            if (opcode == OPCODE_W'(OP_LW) || opcode == OPCODE_W'(OP_SW))
               nxt = ST_ADDR;
            else if (opcode == OPCODE_W'(OP_RTYPE))
               nxt = ST_EXEC;
            else if (opcode == OPCODE_W'(OP_BEQ))
               nxt = ST_BRANCH;
            else if (opcode == OPCODE_W'(OP_J))
               nxt = ST_JUMP;
            else if (opcode == OPCODE_W'(OP_HALT))
               nxt = ST_HALT;
            else
               nxt = ST_HALT;
         end
         ST_ADDR: begin
            if (opcode == OPCODE_W'(OP_LW))
               nxt = ST_MEMRD;
            else if (opcode == OPCODE_W'(OP_SW))
               nxt = ST_MEMWR;
            else
               nxt = ST_HALT;
         end
         ST_MEMRD:  nxt = ST_WBMEM;
         ST_EXEC:   nxt = ST_WBALU;
         ST_WBMEM,
         ST_MEMWR,
         ST_WBALU,
         ST_BRANCH,
         ST_JUMP,
         ST_BOOT:   nxt = ST_FETCH;
         ST_HALT:   nxt = ST_HALT;
         default:   nxt = ST_HALT;
      endcase
      if (start) nxt = ST_BOOT;
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_HALT;
      else     state <= nxt;
   end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
   import mc_ctrl_pkg::*;
#(
   parameter int FETCH_WAIT = 0
) (
   input  state_e state,
   input  logic   fetch_last,
   input  logic   zero,
   output ctrl_t  c,
   output logic   pc_en
);
   logic fetch_pc_wr;

   generate
      if (FETCH_WAIT == 0) begin : g_fold
         assign fetch_pc_wr = fetch_last;
      end else begin : g_split
         assign fetch_pc_wr = 1'b0;
      end
   endgenerate

   always_comb begin
      c = '0;
      unique case (state)
         ST_FETCH: begin
            c.mem_read  = 1'b1;
            c.ir_write  = fetch_last;
            c.pc_write  = fetch_pc_wr;
            c.alu_src_b = SRCB_FOUR;
         end
         ST_PCINC: begin
            c.pc_write  = 1'b1;
            c.alu_src_b = SRCB_FOUR;
         end
         ST_DECODE: begin
            c.a_load      = 1'b1;
            c.b_load      = 1'b1;
            c.aluout_load = 1'b1;
            c.alu_src_b   = SRCB_IMMSH;
         end
         ST_ADDR: begin
            c.aluout_load = 1'b1;
            c.alu_src_a   = 1'b1;
            c.alu_src_b   = SRCB_IMM;
         end
         ST_MEMRD: begin
            c.mem_read     = 1'b1;
            c.mem_addr_sel = 1'b1;
            c.mdr_load     = 1'b1;
         end
         ST_WBMEM: begin
            c.reg_write  = 1'b1;
            c.mem_to_reg = 1'b1;
         end
         ST_MEMWR: begin
            c.mem_write    = 1'b1;
            c.mem_addr_sel = 1'b1;
         end
         ST_EXEC: begin
            c.aluout_load = 1'b1;
            c.alu_src_a   = 1'b1;
            c.alu_src_b   = SRCB_REG;
            c.alu_class   = ALU_FUNCT;
         end
         ST_WBALU: begin
            c.reg_write = 1'b1;
            c.reg_dst   = 1'b1;
         end
         ST_BRANCH: begin
            c.pc_write_cond = 1'b1;
            c.alu_src_a     = 1'b1;
            c.alu_class     = ALU_SUB;
            c.pc_src        = PCS_ALUOUT;
         end
         ST_JUMP: begin
            c.pc_write = 1'b1;
            c.pc_src   = PCS_JUMP;
         end
         ST_BOOT: begin
            c.pc_write = 1'b1;
            c.pc_src   = PCS_BOOT;
         end
         default: c = '0;
      endcase
   end

   assign pc_en = c.pc_write | (c.pc_write_cond & zero);
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mc_ctrl_pkg::*;
#(
   parameter int          FETCH_WAIT = 0,
   parameter int          OPCODE_W   = 6,
   parameter logic [5:0]  OP_RTYPE   = 6'd0,
   parameter logic [5:0]  OP_LW      = 6'd35,
   parameter logic [5:0]  OP_SW      = 6'd43,
   parameter logic [5:0]  OP_BEQ     = 6'd4,
   parameter logic [5:0]  OP_J       = 6'd2,
   parameter logic [5:0]  OP_HALT    = 6'd63
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic [OPCODE_W-1:0] opcode,
   input  logic                zero,
   output logic                ir_write,
   output logic                pc_write,
   output logic                pc_write_cond,
   output logic                pc_en,
   output logic                a_load,
   output logic                b_load,
   output logic                aluout_load,
   output logic                mdr_load,
   output logic                mem_read,
   output logic                mem_write,
   output logic                mem_addr_sel,
   output logic                reg_write,
   output logic                reg_dst,
   output logic                mem_to_reg,
   output logic                alu_src_a,
   output logic [1:0]          alu_src_b,
   output logic [1:0]          alu_class,
   output logic [1:0]          pc_src
);
   generate
      if (OPCODE_W != 6) begin : g_bad_opw
         $error("mc_ctrl_fsm: OPCODE_W must be 6");
      end
      if (FETCH_WAIT < 0 || FETCH_WAIT > 255) begin : g_bad_wait
         $error("mc_ctrl_fsm: FETCH_WAIT must lie in 0..255");
      end
      if (OP_LW == OP_SW || OP_RTYPE == OP_BEQ || OP_BEQ == OP_J) begin : g_bad_op
         $error("mc_ctrl_fsm: opcodes must be distinct");
      end
   endgenerate

   state_e cur_state;
   logic   fetch_last;
   ctrl_t  ctl;

   mc_fetch_timer #(.FETCH_WAIT(FETCH_WAIT)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .in_fetch   (cur_state == ST_FETCH),
      .fetch_last (fetch_last)
   );

   mc_seq #(
      .FETCH_WAIT (FETCH_WAIT),
      .OPCODE_W   (OPCODE_W),
      .OP_RTYPE   (OP_RTYPE),
      .OP_LW      (OP_LW),
      .OP_SW      (OP_SW),
      .OP_BEQ     (OP_BEQ),
      .OP_J       (OP_J),
      .OP_HALT    (OP_HALT)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .opcode     (opcode),
      .fetch_last (fetch_last),
      .state      (cur_state)
   );

   mc_out_decode #(.FETCH_WAIT(FETCH_WAIT)) u_dec (
      .state      (cur_state),
      .fetch_last (fetch_last),
      .zero       (zero),
      .c          (ctl),
      .pc_en      (pc_en)
   );

   assign ir_write      = ctl.ir_write;
   assign pc_write      = ctl.pc_write;
   assign pc_write_cond = ctl.pc_write_cond;
   assign a_load        = ctl.a_load;
   assign b_load        = ctl.b_load;
   assign aluout_load   = ctl.aluout_load;
   assign mdr_load      = ctl.mdr_load;
   assign mem_read      = ctl.mem_read;
   assign mem_write     = ctl.mem_write;
   assign mem_addr_sel  = ctl.mem_addr_sel;
   assign reg_write     = ctl.reg_write;
   assign reg_dst       = ctl.reg_dst;
   assign mem_to_reg    = ctl.mem_to_reg;
   assign alu_src_a     = ctl.alu_src_a;
   assign alu_src_b     = ctl.alu_src_b;
   assign alu_class     = ctl.alu_class;
   assign pc_src        = ctl.pc_src;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
   import mc_ctrl_pkg::*;
#(
   parameter int         FETCH_WAIT = 0,
   parameter int         OPCODE_W   = 6,
   parameter logic [5:0] OP_RTYPE   = 6'd0
) (
   input logic                clk,
   input logic                rst,
   input logic                start,
   input logic [OPCODE_W-1:0] opcode,
   input logic                zero,
   input logic                ir_write,
   input logic                pc_write,
   input logic                pc_write_cond,
   input logic                pc_en,
   input logic                a_load,
   input logic                b_load,
   input logic                aluout_load,
   input logic                mdr_load,
   input logic                mem_read,
   input logic                mem_write,
   input logic                mem_addr_sel,
   input logic                reg_write,
   input logic                reg_dst,
   input logic                mem_to_reg,
   input logic                alu_src_a,
   input logic [1:0]          alu_src_b,
   input logic [1:0]          alu_class,
   input logic [1:0]          pc_src
);
   a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
      !(mem_read && mem_write));

   a_r2_start_boot: assert property (@(posedge clk) disable iff (rst)
      start |=> (pc_write && pc_src == PCS_BOOT && !mem_read));

   a_r3_fetch_from_pc: assert property (@(posedge clk) disable iff (rst)
      ir_write |-> (mem_read && !mem_addr_sel));

   a_r4_decode_loads: assert property (@(posedge clk) disable iff (rst)
      a_load |-> (b_load && aluout_load && !alu_src_a && alu_src_b == SRCB_IMMSH));

   a_r5_rtype_dispatch: assert property (@(posedge clk) disable iff (rst)
      (a_load && !start && opcode == OPCODE_W'(OP_RTYPE)) |=>
         (aluout_load && alu_class == ALU_FUNCT));

   a_r6_read_then_wb: assert property (@(posedge clk) disable iff (rst)
      (mdr_load && !start) |=> (reg_write && mem_to_reg && !reg_dst));

   a_r8_exec_then_wb: assert property (@(posedge clk) disable iff (rst)
      (aluout_load && alu_class == ALU_FUNCT && !start) |=> (reg_write && reg_dst));

   a_r9_branch_gate: assert property (@(posedge clk) disable iff (rst)
      pc_write_cond |-> (pc_en == zero));

   generate
      if (FETCH_WAIT == 0) begin : g_fold_chk
         a_r11_ir_then_decode: assert property (@(posedge clk) disable iff (rst)
            (ir_write && !start) |=> a_load);
      end else begin : g_split_chk
         a_r11_ir_then_pcinc: assert property (@(posedge clk) disable iff (rst)
            (ir_write && !start) |=>
               (pc_write && pc_src == PCS_ALU && !mem_read && !ir_write));
         a_r11_no_pc_in_fetch: assert property (@(posedge clk) disable iff (rst)
            (mem_read && !mem_addr_sel) |-> !pc_write);
      end
   endgenerate
endmodule

bind mc_ctrl_fsm mc_ctrl_chk #(
   .FETCH_WAIT (FETCH_WAIT),
   .OPCODE_W   (OPCODE_W),
   .OP_RTYPE   (OP_RTYPE)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .start         (start),
   .opcode        (opcode),
   .zero          (zero),
   .ir_write      (ir_write),
   .pc_write      (pc_write),
   .pc_write_cond (pc_write_cond),
   .pc_en         (pc_en),
   .a_load        (a_load),
   .b_load        (b_load),
   .aluout_load   (aluout_load),
   .mdr_load      (mdr_load),
   .mem_read      (mem_read),
   .mem_write     (mem_write),
   .mem_addr_sel  (mem_addr_sel),
   .reg_write     (reg_write),
   .reg_dst       (reg_dst),
   .mem_to_reg    (mem_to_reg),
   .alu_src_a     (alu_src_a),
   .alu_src_b     (alu_src_b),
   .alu_class     (alu_class),
   .pc_src        (pc_src)
);

// File: tb/mc_ctrl_fsm_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb_top;

   localparam int S_FETCH = 0, S_DECODE = 1, S_ADDR = 2, S_MEMRD = 3, S_WBMEM = 4,
                  S_MEMWR = 5, S_EXEC = 6, S_WBALU = 7, S_BRANCH = 8, S_JUMP = 9,
                  S_HALT = 10, S_BOOT = 11, S_PCINC = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   // copy without fetch wait cycles
   logic       m_start = 1'b0;
   logic [5:0] m_op    = 6'd0;
   logic       m_zero  = 1'b0;
   logic m_ir, m_pcw, m_pcc, m_pcen, m_al, m_bl, m_aol, m_mdr, m_mr, m_mw, m_mas;
   logic m_rw, m_rd, m_m2r, m_asa;
   logic [1:0] m_asb, m_ac, m_ps;
   logic [20:0] act_m;
   assign act_m = {m_ir, m_pcw, m_pcc, m_pcen, m_al, m_bl, m_aol, m_mdr, m_mr, m_mw,
                   m_mas, m_rw, m_rd, m_m2r, m_asa, m_asb, m_ac, m_ps};

   mc_ctrl_fsm #(.FETCH_WAIT(0)) dut_i (
      .clk(clk), .rst(rst), .start(m_start), .opcode(m_op), .zero(m_zero),
      .ir_write(m_ir), .pc_write(m_pcw), .pc_write_cond(m_pcc), .pc_en(m_pcen),
      .a_load(m_al), .b_load(m_bl), .aluout_load(m_aol), .mdr_load(m_mdr),
      .mem_read(m_mr), .mem_write(m_mw), .mem_addr_sel(m_mas), .reg_write(m_rw),
      .reg_dst(m_rd), .mem_to_reg(m_m2r), .alu_src_a(m_asa), .alu_src_b(m_asb),
      .alu_class(m_ac), .pc_src(m_ps));

   // copy with two fetch wait cycles
   logic       w_start = 1'b0;
   logic [5:0] w_op    = 6'd0;
   logic       w_zero  = 1'b0;
   logic w_ir, w_pcw, w_pcc, w_pcen, w_al, w_bl, w_aol, w_mdr, w_mr, w_mw, w_mas;
   logic w_rw, w_rd, w_m2r, w_asa;
   logic [1:0] w_asb, w_ac, w_ps;
   logic [20:0] act_w;
   assign act_w = {w_ir, w_pcw, w_pcc, w_pcen, w_al, w_bl, w_aol, w_mdr, w_mr, w_mw,
                   w_mas, w_rw, w_rd, w_m2r, w_asa, w_asb, w_ac, w_ps};

   mc_ctrl_fsm #(.FETCH_WAIT(2)) dut_w_i (
      .clk(clk), .rst(rst), .start(w_start), .opcode(w_op), .zero(w_zero),
      .ir_write(w_ir), .pc_write(w_pcw), .pc_write_cond(w_pcc), .pc_en(w_pcen),
      .a_load(w_al), .b_load(w_bl), .aluout_load(w_aol), .mdr_load(w_mdr),
      .mem_read(w_mr), .mem_write(w_mw), .mem_addr_sel(w_mas), .reg_write(w_rw),
      .reg_dst(w_rd), .mem_to_reg(w_m2r), .alu_src_a(w_asa), .alu_src_b(w_asb),
      .alu_class(w_ac), .pc_src(w_ps));

   // expected outputs per state, built from the requirement text
   function automatic logic [20:0] expv(input int st, input bit last, input bit z,
                                        input bit fold);
      logic ir = 0, pcw = 0, pcc = 0, al = 0, bl = 0, aol = 0, mdr = 0, mr = 0;
      logic mw = 0, mas = 0, rw = 0, rd = 0, m2r = 0, asa = 0, pcen;
      logic [1:0] asb = 0, ac = 0, ps = 0;
      case (st)
         S_FETCH:  begin mr = 1; ir = last; pcw = fold & last; asb = 2'd1; end
         S_PCINC:  begin pcw = 1; asb = 2'd1; end
         S_DECODE: begin al = 1; bl = 1; aol = 1; asb = 2'd3; end
         S_ADDR:   begin aol = 1; asa = 1; asb = 2'd2; end
         S_MEMRD:  begin mr = 1; mas = 1; mdr = 1; end
         S_WBMEM:  begin rw = 1; m2r = 1; end
         S_MEMWR:  begin mw = 1; mas = 1; end
         S_EXEC:   begin aol = 1; asa = 1; ac = 2'd2; end
         S_WBALU:  begin rw = 1; rd = 1; end
         S_BRANCH: begin pcc = 1; asa = 1; ac = 2'd1; ps = 2'd1; end
         S_JUMP:   begin pcw = 1; ps = 2'd2; end
         S_BOOT:   begin pcw = 1; ps = 2'd3; end
         default:  ;
      endcase
      pcen = pcw | (pcc & z);
      return {ir, pcw, pcc, pcen, al, bl, aol, mdr, mr, mw, mas, rw, rd, m2r, asa, asb, ac, ps};
   endfunction

   task automatic chk(input logic [20:0] act, input logic [20:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step_m(input int st, input string req);
      @(posedge clk);
      @(negedge clk);
      chk(act_m, expv(st, 1'b1, m_zero, 1'b1), req);
   endtask

   task automatic step_w(input int st, input bit last, input string req);
      @(posedge clk);
      @(negedge clk);
      chk(act_w, expv(st, last, w_zero, 1'b0), req);
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(act_m, expv(S_HALT, 1, 0, 1), "R1 in reset");
      chk(act_w, expv(S_HALT, 0, 0, 0), "R1 in reset (wait copy)");
      rst  = 1'b0;
      m_op = 6'd0;
      for (int i = 0; i < 3; i++) step_m(S_HALT, "R1 idle after reset");
   endtask

   task automatic t_boot;
      m_start = 1'b1;
      step_m(S_BOOT, "R2 boot cycle");
      m_start = 1'b0;
      step_m(S_FETCH, "R3 fetch");
   endtask

   task automatic t_lw;
      m_op = 6'd35;
      step_m(S_DECODE, "R4 decode lw");
      step_m(S_ADDR,   "R5 lw to address");
      step_m(S_MEMRD,  "R6 memory read");
      step_m(S_WBMEM,  "R6 write-back rt");
      step_m(S_FETCH,  "R6 back to fetch");
   endtask

   task automatic t_sw;
      m_op = 6'd43;
      step_m(S_DECODE, "R4 decode sw");
      step_m(S_ADDR,   "R5 sw to address");
      step_m(S_MEMWR,  "R7 memory write");
      step_m(S_FETCH,  "R7 back to fetch");
   endtask

   task automatic t_rtype;
      m_op = 6'd0;
      step_m(S_DECODE, "R4 decode rtype");
      step_m(S_EXEC,   "R8 execute");
      step_m(S_WBALU,  "R8 write-back rd");
      step_m(S_FETCH,  "R8 back to fetch");
   endtask

   task automatic t_beq(input bit z);
      m_op   = 6'd4;
      m_zero = z;
      step_m(S_BRANCH == 0 ? S_DECODE : S_DECODE, "R4 decode beq");
      step_m(S_BRANCH, "R9 branch cycle");
      m_zero = !z;
      #1;
      chk(act_m, expv(S_BRANCH, 1, !z, 1), "R9 pc_en follows zero");
      m_zero = 1'b0;
      step_m(S_FETCH, "R9 back to fetch");
   endtask

   task automatic t_jump;
      m_op = 6'd2;
      step_m(S_DECODE, "R4 decode j");
      step_m(S_JUMP,   "R10 jump cycle");
      step_m(S_FETCH,  "R10 back to fetch");
   endtask

   task automatic t_start_mid;
      m_op = 6'd0;
      step_m(S_DECODE, "R4 decode before restart");
      step_m(S_EXEC,   "R8 execute before restart");
      m_start = 1'b1;
      step_m(S_BOOT,   "R2 restart mid-instruction");
      m_start = 1'b0;
      step_m(S_FETCH,  "R2 fetch after restart");
   endtask

   task automatic t_halt_op(input logic [5:0] op, input string req);
      m_op = op;
      step_m(S_DECODE, "R4 decode halting opcode");
      step_m(S_HALT, req);
      m_op = 6'd35;
      step_m(S_HALT, "R5 halt holds on new opcode");
      m_op = 6'd0;
      step_m(S_HALT, "R5 halt holds on rtype opcode");
      m_start = 1'b1;
      step_m(S_BOOT, "R2 boot from halt");
      m_start = 1'b0;
      step_m(S_FETCH, "R3 fetch after halt");
   endtask

   task automatic t_wait_fetch;
      w_op = 6'd0;
      w_start = 1'b1;
      step_w(S_BOOT, 0, "R2 boot (wait copy)");
      w_start = 1'b0;
      step_w(S_FETCH, 0, "R11 fetch wait 1");
      step_w(S_FETCH, 0, "R11 fetch wait 2");
      step_w(S_FETCH, 1, "R11 fetch last with ir_write");
      step_w(S_PCINC, 0, "R11 pc increment cycle");
      step_w(S_DECODE, 0, "R11 decode after increment");
      step_w(S_EXEC, 0, "R8 execute (wait copy)");
      step_w(S_WBALU, 0, "R8 write-back (wait copy)");
      step_w(S_FETCH, 0, "R11 second fetch restarts count");
      step_w(S_FETCH, 0, "R11 second fetch wait 2");
      step_w(S_FETCH, 1, "R11 second fetch last");
   endtask

   initial begin
      t_reset();
      t_boot();
      t_lw();
      t_sw();
      t_rtype();
      t_beq(1'b1);
      t_beq(1'b0);
      t_jump();
      t_start_mid();
      t_halt_op(6'd63, "R5 halt opcode");
      t_halt_op(6'd13, "R5 unknown opcode halts");
      t_wait_fetch();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule